// File: doc/BRIEF.md
# LIN Bus Error Monitor

This block sits beside a LIN controller and watches both sides of its transceiver. It takes the transmitted bit stream and the sampled receive line, and a set of strobes from the controller: a mid-bit sample enable, frame start, frame active, byte complete, and break-or-wakeup detected. From these it raises three sticky flags. The physical bus error flag reports a bus held dominant. The bit error flag reports a read-back mismatch or stray traffic. The receive-ready flag reports that a byte arrived outside any frame.

Three detectors run in parallel. The first counts consecutive low samples while a frame is in progress. The second catches bytes that arrive when no frame is active. When that happens it blocks further frame checking until the controller confirms that the receive data has been read. The third compares the transmitted and received bits. The mode input selects how: in standard mode the whole byte is compared at the end of each byte field, and in fast mode each bit is compared as it is sampled, which gives an early error indication.

Top module: `lin_err_monitor`

## Requirements
- R1: While frame active is high, the physical bus error flag sets after 31 consecutive sample strobes with the receive line low. It is visible the clock after the 31st such sample, and it is not set after 30.
- R2: The count of low samples restarts on any sample with the receive line high, on a frame start, and whenever frame active is low.
- R3: A byte-complete strobe with frame active low and break/wakeup low sets the bit error flag, sets the receive-ready flag and raises the blocked output. If break/wakeup is high on that strobe, none of these change.
- R4: The blocked output stays high until a read-acknowledge pulse. While it is high, neither bit comparison can set the bit error flag.
- R5: In standard mode (fast mode input 0), each byte-complete strobe inside a frame compares the 8 transmit bits with the 8 receive bits sampled since the previous byte-complete or frame start. A difference sets the bit error flag on the next clock, and equal bytes leave it clear.
- R6: In fast mode (fast mode input 1), a sample strobe inside a frame where the transmit bit differs from the receive bit sets the bit error flag on the next clock. The end-of-byte comparison is not made in this mode.
- R7: The flags are sticky. Clear input bit 0 clears the physical bus error flag, bit 1 clears the bit error flag and bit 2 clears the receive-ready flag. A 1 clears the flag, and a set in the same cycle wins over the clear.
- R8: On each byte-complete strobe, the receive byte output captures the last 8 receive samples, with the first sample in bit 0.
- R9: After reset, all flags, the blocked output and the receive byte output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleEn | input | 1 | Mid-bit sample strobe |
| txBit | input | 1 | Bit being driven onto the bus |
| rxBit | input | 1 | Receive line level |
| frameStart | input | 1 | Frame transmission begins |
| frameActive | input | 1 | High for the duration of an own frame |
| byteDone | input | 1 | A byte field has completed |
| breakWake | input | 1 | The completed byte was a break or wakeup character |
| fastMode | input | 1 | 1 selects per-bit checking, 0 selects end-of-byte checking |
| clrFlags | input | 3 | Write-1 clear: bit0 physical, bit1 bit error, bit2 receive ready |
| rxReadAck | input | 1 | Receive data has been read |
| physErr | output | 1 | Sticky physical bus error |
| bitErr | output | 1 | Sticky bit error |
| rxReady | output | 1 | Sticky receive-ready |
| opBlocked | output | 1 | Frame checking suspended after a stray byte |
| rxByte | output | 8 | Last captured receive byte |

## Verification
The hardest situation to reach is the boundary of the dominant-bus timeout. Getting there takes long runs of low samples that must stay unbroken and must fall inside an active frame. The stimulus sweeps run lengths from 28 to 33 and checks the flag at each one. It also breaks a 30-sample run with one high sample or with a frame drop, then follows with another 30, so a counter that fails to restart would cross the limit. The byte comparison is swept over all 256 transmit values, each paired with either an equal read-back or a single flipped bit. The blocked state is entered with a stray byte, and a mismatching frame is then driven while blocked.

// File: rtl/lin_mon_pkg.sv
package lin_mon_pkg;
  localparam int FLAG_PHYS = 0;
  localparam int FLAG_BIT  = 1;
  localparam int FLAG_RDY  = 2;
  localparam int NUM_FLAGS = 3;

  typedef struct packed {
    logic shiftEn;
    logic shiftClr;
    logic capture;
    logic lowCount;
    logic lowClear;
  } dpCtrl_t;

  typedef struct packed {
    logic lowHit;
    logic bitMiss;
    logic byteMiss;
  } dpStat_t;
endpackage

// File: rtl/lin_mon_datapath.sv
module lin_mon_datapath
  import lin_mon_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int LOW_LIMIT = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txBit,
  input  logic              rxBit,
  input  dpCtrl_t           dp,
  output dpStat_t           stat,
  output logic [BYTE_W-1:0] rxByte
);
  localparam int CNT_W = $clog2(LOW_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOW_LIMIT);
  localparam logic [CNT_W-1:0] CNT_PRE = CNT_W'(LOW_LIMIT - 1);

  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] rxShift;
  logic [CNT_W-1:0]  lowCnt;

  // serial assembly, first sample ends in bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else if (dp.shiftClr) begin
      txShift <= '0;
      rxShift <= '0;
    end else if (dp.shiftEn) begin
      txShift <= {txBit, txShift[BYTE_W-1:1]};
      rxShift <= {rxBit, rxShift[BYTE_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rxByte <= '0;
    else if (dp.capture) rxByte <= rxShift;
  end

  // saturating dominant-run counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (dp.lowClear) begin
      lowCnt <= '0;
    end else if (dp.lowCount) begin
      if (rxBit)                lowCnt <= '0;
      else if (lowCnt != CNT_MAX) lowCnt <= lowCnt + 1'b1;
    end
  end

  always_comb begin
    stat.lowHit   = dp.lowCount && !dp.lowClear && !rxBit && (lowCnt == CNT_PRE);
    stat.bitMiss  = txBit != rxBit;
    stat.byteMiss = txShift != rxShift;
  end
endmodule

// File: rtl/lin_mon_ctrl.sv
module lin_mon_ctrl
  import lin_mon_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleEn,
  input  logic                 frameStart,
  input  logic                 frameActive,
  input  logic                 byteDone,
  input  logic                 breakWake,
  input  logic                 fastMode,
  input  logic [NUM_FLAGS-1:0] clrFlags,
  input  logic                 rxReadAck,
  input  dpStat_t              stat,
  output dpCtrl_t              dp,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 opBlocked
);
  logic strayByte;
  logic cmpBit;
  logic cmpByte;
  logic [NUM_FLAGS-1:0] setVec;

  always_comb begin
    dp.shiftEn  = sampleEn;
    dp.shiftClr = byteDone || frameStart;
    dp.capture  = byteDone;
    dp.lowCount = sampleEn && frameActive;
    dp.lowClear = frameStart || !frameActive;
  end

  always_comb begin
    strayByte = byteDone && !frameActive && !breakWake;
    cmpBit    = sampleEn && frameActive && fastMode && !opBlocked;
    cmpByte   = byteDone && frameActive && !fastMode && !opBlocked;
    setVec              = '0;
    setVec[FLAG_PHYS]   = stat.lowHit;
    setVec[FLAG_BIT]    = strayByte || (cmpBit && stat.bitMiss) || (cmpByte && stat.byteMiss);
    setVec[FLAG_RDY]    = strayByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
    end else begin
      for (int i = 0; i < NUM_FLAGS; i++)
        flags[i] <= setVec[i] | (flags[i] & ~clrFlags[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          opBlocked <= 1'b0;
    else if (strayByte) opBlocked <= 1'b1;
    else if (rxReadAck) opBlocked <= 1'b0;
  end
endmodule

// File: rtl/lin_err_monitor.sv
module lin_err_monitor
  import lin_mon_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int LOW_LIMIT = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleEn,
  input  logic              txBit,
  input  logic              rxBit,
  input  logic              frameStart,
  input  logic              frameActive,
  input  logic              byteDone,
  input  logic              breakWake,
  input  logic              fastMode,
  input  logic [2:0]        clrFlags,
  input  logic              rxReadAck,
  output logic              physErr,
  output logic              bitErr,
  output logic              rxReady,
  output logic              opBlocked,
  output logic [BYTE_W-1:0] rxByte
);
  dpCtrl_t dpCtl;
  dpStat_t dpSt;
  logic [NUM_FLAGS-1:0] flagVec;

  lin_mon_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .frameStart(frameStart),
    .frameActive(frameActive), .byteDone(byteDone), .breakWake(breakWake),
    .fastMode(fastMode), .clrFlags(clrFlags), .rxReadAck(rxReadAck),
    .stat(dpSt), .dp(dpCtl), .flags(flagVec), .opBlocked(opBlocked)
  );

  lin_mon_datapath #(.BYTE_W(BYTE_W), .LOW_LIMIT(LOW_LIMIT)) uDp (
    .clk(clk), .rstN(rstN), .txBit(txBit), .rxBit(rxBit),
    .dp(dpCtl), .stat(dpSt), .rxByte(rxByte)
  );

  assign physErr = flagVec[FLAG_PHYS];
  assign bitErr  = flagVec[FLAG_BIT];
  assign rxReady = flagVec[FLAG_RDY];
endmodule

// File: rtl/lin_mon_checker.sv
module lin_mon_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sampleEn,
  input logic       txBit,
  input logic       rxBit,
  input logic       frameActive,
  input logic       byteDone,
  input logic       breakWake,
  input logic       fastMode,
  input logic [2:0] clrFlags,
  input logic       rxReadAck,
  input logic       physErr,
  input logic       bitErr,
  input logic       rxReady,
  input logic       opBlocked
);
  // R1: the physical flag only rises right after a low sample in a frame
  a_r1_phys_after_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(physErr) |-> $past(sampleEn && frameActive && !rxBit));

  // R3: a stray byte raises ready and blocking
  a_r3_stray_byte: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && !frameActive && !breakWake) |=> (rxReady && opBlocked && bitErr));

  // R4: blocking is only released by a read
  a_r4_block_hold: assert property (@(posedge clk) disable iff (!rstN)
    $fell(opBlocked) |-> $past(rxReadAck));

  // R6: per-bit mismatch in fast mode flags at once
  a_r6_fast_bit: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && frameActive && fastMode && !opBlocked && (txBit != rxBit)) |=> bitErr);

  // R5: in standard mode the bit flag rises only at a byte boundary
  a_r5_byte_only: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(bitErr) && $past(!fastMode)) |-> $past(byteDone));

  // R7: sticky flags fall only through their clear bits
  a_r7_sticky_phys: assert property (@(posedge clk) disable iff (!rstN)
    $fell(physErr) |-> $past(clrFlags[0]));
  a_r7_sticky_bit: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bitErr) |-> $past(clrFlags[1]));
  a_r7_sticky_rdy: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxReady) |-> $past(clrFlags[2]));
endmodule

bind lin_err_monitor lin_mon_checker uChk (
  .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .txBit(txBit), .rxBit(rxBit),
  .frameActive(frameActive), .byteDone(byteDone), .breakWake(breakWake),
  .fastMode(fastMode), .clrFlags(clrFlags), .rxReadAck(rxReadAck),
  .physErr(physErr), .bitErr(bitErr), .rxReady(rxReady), .opBlocked(opBlocked)
);

// File: tb/lin_err_monitor_test.sv
module lin_err_monitor_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rstN = 0;
  logic sampleEn = 0, txBit = 1, rxBit = 1;
  logic frameStart = 0, frameActive = 0, byteDone = 0, breakWake = 0;
  logic fastMode = 0, rxReadAck = 0;
  logic [2:0] clrFlags = '0;
  logic physErr, bitErr, rxReady, opBlocked;
  logic [7:0] rxByte;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_err_monitor uut (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .txBit(txBit), .rxBit(rxBit),
    .frameStart(frameStart), .frameActive(frameActive), .byteDone(byteDone),
    .breakWake(breakWake), .fastMode(fastMode), .clrFlags(clrFlags),
    .rxReadAck(rxReadAck), .physErr(physErr), .bitErr(bitErr),
    .rxReady(rxReady), .opBlocked(opBlocked), .rxByte(rxByte)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sampleBit(input logic tx, input logic rx);
    @(negedge clk); sampleEn = 1; txBit = tx; rxBit = rx;
    @(negedge clk); sampleEn = 0;
  endtask

  task automatic endByte(input logic brk);
    @(negedge clk); byteDone = 1; breakWake = brk;
    @(negedge clk); byteDone = 0; breakWake = 0;
  endtask

  task automatic beginFrame();
    @(negedge clk); frameStart = 1; frameActive = 1;
    @(negedge clk); frameStart = 0;
  endtask

  task automatic dropFrame();
    @(negedge clk); frameActive = 0;
    @(negedge clk);
  endtask

  task automatic clearAll(input logic [2:0] m);
    @(negedge clk); clrFlags = m;
    @(negedge clk); clrFlags = '0;
  endtask

  task automatic readAck();
    @(negedge clk); rxReadAck = 1;
    @(negedge clk); rxReadAck = 0;
  endtask

  task automatic sendByte(input logic [7:0] tx, input logic [7:0] rx);
    for (int b = 0; b < 8; b++) sampleBit(tx[b], rx[b]);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 physErr", physErr, 0);
    chk("R9 bitErr", bitErr, 0);
    chk("R9 rxReady", rxReady, 0);
    chk("R9 opBlocked", opBlocked, 0);
    chk("R9 rxByte", rxByte, 0);
    rstN = 1;
    @(negedge clk);

    // R1: run lengths around the limit
    for (int n = 28; n <= 33; n++) begin
      beginFrame();
      for (int k = 0; k < n; k++) begin
        sampleBit(0, 0);
        if (k == 29) chk("R1 no flag at 30", physErr, 0);
      end
      chk("R1 flag vs run length", physErr, (n >= 31) ? 1 : 0);
      dropFrame();
      clearAll(3'b111);
      chk("R7 phys cleared", physErr, 0);
    end

    // R2: broken by a high sample
    beginFrame();
    for (int k = 0; k < 30; k++) sampleBit(0, 0);
    sampleBit(1, 1);
    for (int k = 0; k < 30; k++) sampleBit(0, 0);
    chk("R2 high sample restarts", physErr, 0);
    // R2: broken by frame drop
    dropFrame();
    @(negedge clk); frameActive = 1;
    for (int k = 0; k < 30; k++) sampleBit(0, 0);
    chk("R2 frame drop restarts", physErr, 0);
    dropFrame();
    clearAll(3'b111);

    // R5 and R8: standard byte sweep
    fastMode = 0;
    for (int v = 0; v < 256; v++) begin
      for (int m = 0; m < 2; m++) begin
        logic [7:0] rx;
        rx = (m == 0) ? v[7:0] : (v[7:0] ^ (8'h01 << (v % 8)));
        beginFrame();
        sendByte(v[7:0], rx);
        chk("R5 no flag before byte end", bitErr, 0);
        endByte(0);
        chk("R5 byte compare", bitErr, (m == 0) ? 0 : 1);
        chk("R8 rxByte capture", rxByte, rx);
        dropFrame();
        clearAll(3'b010);
      end
    end

    // R6: fast mode, one flipped bit at each position
    fastMode = 1;
    for (int p = 0; p < 8; p++) begin
      beginFrame();
      for (int b = 0; b < 8; b++) begin
        sampleBit(b[0], (b == p) ? ~b[0] : b[0]);
        chk("R6 fast flag timing", bitErr, (b >= p) ? 1 : 0);
      end
      endByte(0);
      dropFrame();
      clearAll(3'b010);
    end
    // R6: end-of-byte compare skipped; the flag stays clear after each cleared bit error
    beginFrame();
    sendByte(8'hA5, 8'hA4);
    clearAll(3'b010);
    endByte(0);
    chk("R6 no byte compare in fast mode", bitErr, 0);
    dropFrame();
    fastMode = 0;

    // R3: break/wakeup byte outside frame
    sendByte(8'h00, 8'h00);
    endByte(1);
    chk("R3 break ignored bitErr", bitErr, 0);
    chk("R3 break ignored rxReady", rxReady, 0);
    chk("R3 break ignored blocked", opBlocked, 0);
    // R3: stray byte
    sendByte(8'h55, 8'h3C);
    endByte(0);
    chk("R3 stray bitErr", bitErr, 1);
    chk("R3 stray rxReady", rxReady, 1);
    chk("R3 stray blocked", opBlocked, 1);
    chk("R8 stray rxByte", rxByte, 8'h3C);

    // R7: selective clear
    clearAll(3'b010);
    chk("R7 bit cleared", bitErr, 0);
    chk("R7 ready kept", rxReady, 1);

    // R4: blocked suppresses both comparisons
    beginFrame();
    sendByte(8'hF0, 8'h0F);
    endByte(0);
    chk("R4 standard suppressed", bitErr, 0);
    fastMode = 1;
    sendByte(8'hF0, 8'h0F);
    chk("R4 fast suppressed", bitErr, 0);
    fastMode = 0;
    dropFrame();
    chk("R4 still blocked", opBlocked, 1);
    readAck();
    chk("R4 released by read", opBlocked, 0);
    beginFrame();
    sendByte(8'hF0, 8'h0F);
    endByte(0);
    chk("R4 checks resume", bitErr, 1);
    dropFrame();
    clearAll(3'b111);
    readAck();

    // R7: set wins over clear
    sendByte(8'h11, 8'h22);
    @(negedge clk); byteDone = 1; clrFlags = 3'b110;
    @(negedge clk); byteDone = 0; clrFlags = '0;
    chk("R7 set wins bitErr", bitErr, 1);
    chk("R7 set wins rxReady", rxReady, 1);
    clearAll(3'b111);
    chk("R7 all cleared", bitErr + rxReady + physErr, 0);
    readAck();

    done = 1;
    summary();
  end
endmodule